// File: doc/BRIEF.md
# ISA Command Wait-State Sequencer

This block times the command phase of an ISA bus cycle run by a bus master. A one-clock start strobe, taken only while the sequencer is idle, captures four things: the cycle kind (memory or I/O), the direction, the 16-bit chip-select reply that matches the cycle kind, and whether the address lies in the first megabyte. From the next SYSCLK on, exactly one command strobe is held low. Each clock of the command is counted. The command ends on the first rising edge where the slave's ready line is high and the required length has been reached. That length is either the normal length or, when the slave asks for zero wait states and the cycle kind permits it, the shortened length.

The controller has three states. IDLE waits for a start strobe. CMD holds the command strobe and counts clocks. DONE drives a one-clock completion pulse with every strobe released. The transitions are:
- IDLE to CMD when start is sampled high.
- CMD to CMD while the end condition is false.
- CMD to DONE when the end condition is true.
- DONE to IDLE unconditionally.

For memory cycles whose address is below 1 MB, a standard-memory read or write strobe follows the memory command. Its leading edge comes one clock later and it is released together with the command.

Top module: `isa_cmd_timer`

## Requirements
- R1: A start strobe sampled high in IDLE drives exactly one command strobe low from the next clock. The strobe is chosen as follows: memory read gives memr_n, memory write gives memw_n, I/O read gives ior_n and I/O write gives iow_n. The other three strobes stay high.
- R2: With zerows_n high and iochrdy high, the command lasts 3 clocks for a 16-bit memory cycle and 6 clocks for 8-bit memory, 8-bit I/O and 16-bit I/O cycles.
- R3: With zerows_n sampled low, a 16-bit memory command lasts 2 clocks and an 8-bit memory or 8-bit I/O command lasts 3 clocks.
- R4: zerows_n has no effect on a 16-bit I/O cycle, which keeps its 6-clock length.
- R5: iochrdy sampled low on a clock holds the command for at least one more clock, even when zerows_n is sampled low on the same clock. The command ends on the first clock at or after its required length on which iochrdy is sampled high.
- R6: A memory cycle takes its width from memcs16_n and an I/O cycle takes it from iocs16_n (low means 16-bit). The select that does not match the cycle kind has no effect on its length.
- R7: On the clock after the command strobe rises, done is high for exactly one clock with all command strobes high.
- R8: A start strobe sampled during CMD or DONE is ignored. No command follows the DONE clock unless a new start arrives in IDLE.
- R9: smemr_n (smemw_n) goes low from the second command clock until the end of a memory read (write) cycle whose address bits 23..20 are all zero. In every other case it stays high.
- R10: During and after reset with no start, every strobe is high and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SYSCLK |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a cycle; sampled only in IDLE |
| is_mem | input | 1 | 1 selects a memory cycle, 0 an I/O cycle |
| is_wr | input | 1 | 1 selects a write, 0 a read |
| memcs16_n | input | 1 | 16-bit memory slave reply, active low |
| iocs16_n | input | 1 | 16-bit I/O slave reply, active low |
| addr | input | ADDR_W | Cycle address, used for the below-1 MB test |
| iochrdy | input | 1 | Slave ready; low requests wait states |
| zerows_n | input | 1 | Slave zero-wait request, active low |
| ior_n | output | 1 | I/O read command |
| iow_n | output | 1 | I/O write command |
| memr_n | output | 1 | Memory read command |
| memw_n | output | 1 | Memory write command |
| smemr_n | output | 1 | Standard memory read, below 1 MB only |
| smemw_n | output | 1 | Standard memory write, below 1 MB only |
| done | output | 1 | One-clock completion pulse |

## Verification
Two arbitration inputs can act on the same clock: a zero-wait request from the slave and a wait request from the slave, each of which tries to set the end of the command. The bench holds zerows_n low for the whole command and pulls iochrdy low over windows that start before, at and after the clock on which the shortened cycle would end. The command must then run to the first clock on which ready is high, and never stop on the shortened count. It computes the expected length as the larger of the applicable minimum and the end of any wait window that covers that minimum, and compares it with the measured strobe width.

// File: rtl/isa_wait_pkg.sv
package isa_wait_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DONE = 2'd2
    } phase_t;

    typedef struct packed {
        logic mem;   // 1: memory cycle
        logic wr;    // 1: write
        logic wide;  // 1: 16-bit slave
        logic low;   // 1: address in first megabyte
    } xfer_t;

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/isa_addr_qual.sv
module isa_addr_qual #(
    parameter int ADDR_W   = 24,
    parameter int LOW_BITS = 20
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              below
);
    generate
        if (ADDR_W <= LOW_BITS) begin : g_all_low
            logic unused_addr;
            assign unused_addr = ^addr;
            assign below       = 1'b1;
        end else begin : g_cmp
            logic unused_low;
            assign unused_low = ^addr[LOW_BITS-1:0];
            assign below      = (addr[ADDR_W-1:LOW_BITS] == '0);
        end
    endgenerate
endmodule

// File: rtl/isa_len_sel.sv
module isa_len_sel #(
    parameter int CNT_W      = 3,
    parameter int LEN_MEM16  = 3,
    parameter int LEN_MEM8   = 6,
    parameter int LEN_IO8    = 6,
    parameter int LEN_IO16   = 6,
    parameter int ZW_MEM16   = 2,
    parameter int ZW_NARROW  = 3
) (
    input  logic             is_mem,
    input  logic             is_wide,
    output logic [CNT_W-1:0] full_len,
    output logic [CNT_W-1:0] zw_len,
    output logic             zw_ok
);
    always_comb begin
        unique case ({is_mem, is_wide})
            2'b11: begin
                full_len = CNT_W'(LEN_MEM16);
                zw_len   = CNT_W'(ZW_MEM16);
            end
            2'b10: begin
                full_len = CNT_W'(LEN_MEM8);
                zw_len   = CNT_W'(ZW_NARROW);
            end
            2'b01: begin
                full_len = CNT_W'(LEN_IO16);
                zw_len   = CNT_W'(LEN_IO16);
            end
            default: begin
                full_len = CNT_W'(LEN_IO8);
                zw_len   = CNT_W'(ZW_NARROW);
            end
        endcase
        // 16-bit I/O never takes the shortened path
        zw_ok = is_mem || !is_wide;
    end
endmodule

// File: rtl/isa_cmd_cnt.sv
module isa_cmd_cnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= CNT_W'(1);
        end else if (step && (cnt != '1)) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/isa_cmd_timer.sv
module isa_cmd_timer
    import isa_wait_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int LOW_BITS   = 20,
    parameter int LEN_MEM16  = 3,
    parameter int LEN_MEM8   = 6,
    parameter int LEN_IO8    = 6,
    parameter int LEN_IO16   = 6,
    parameter int ZW_MEM16   = 2,
    parameter int ZW_NARROW  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_mem,
    input  logic              is_wr,
    input  logic              memcs16_n,
    input  logic              iocs16_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              iochrdy,
    input  logic              zerows_n,
    output logic              ior_n,
    output logic              iow_n,
    output logic              memr_n,
    output logic              memw_n,
    output logic              smemr_n,
    output logic              smemw_n,
    output logic              done
);
    localparam int MAX_LEN = imax(imax(LEN_MEM16, LEN_MEM8), imax(LEN_IO8, LEN_IO16));
    localparam int CNT_W   = imax(2, $clog2(MAX_LEN + 1));

    phase_t           state_q, state_d;
    xfer_t            xfer_q;
    logic [CNT_W-1:0] cnt, full_len, zw_len;
    logic             zw_ok, below, load, end_now;

    isa_addr_qual #(.ADDR_W(ADDR_W), .LOW_BITS(LOW_BITS)) u_qual (
        .addr  (addr),
        .below (below)
    );

    assign load = (state_q == ST_IDLE) && start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xfer_q <= '0;
        end else if (load) begin
            xfer_q.mem  <= is_mem;
            xfer_q.wr   <= is_wr;
            xfer_q.wide <= is_mem ? !memcs16_n : !iocs16_n;
            xfer_q.low  <= below;
        end
    end

    isa_len_sel #(
        .CNT_W(CNT_W), .LEN_MEM16(LEN_MEM16), .LEN_MEM8(LEN_MEM8),
        .LEN_IO8(LEN_IO8), .LEN_IO16(LEN_IO16),
        .ZW_MEM16(ZW_MEM16), .ZW_NARROW(ZW_NARROW)
    ) u_len (
        .is_mem   (xfer_q.mem),
        .is_wide  (xfer_q.wide),
        .full_len (full_len),
        .zw_len   (zw_len),
        .zw_ok    (zw_ok)
    );

    isa_cmd_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load),
        .step  (state_q == ST_CMD),
        .cnt   (cnt)
    );

    // Ready low overrides any zero-wait request on the same edge
    assign end_now = iochrdy &&
                     ((cnt >= full_len) || (zw_ok && !zerows_n && (cnt >= zw_len)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)   state_d = ST_CMD;
            ST_CMD:  if (end_now) state_d = ST_DONE;
            ST_DONE:              state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ior_n   = 1'b1;
        iow_n   = 1'b1;
        memr_n  = 1'b1;
        memw_n  = 1'b1;
        smemr_n = 1'b1;
        smemw_n = 1'b1;
        done    = 1'b0;
        unique case (state_q)
            ST_CMD: begin
                ior_n   = !(!xfer_q.mem && !xfer_q.wr);
                iow_n   = !(!xfer_q.mem &&  xfer_q.wr);
                memr_n  = !( xfer_q.mem && !xfer_q.wr);
                memw_n  = !( xfer_q.mem &&  xfer_q.wr);
                smemr_n = !( xfer_q.mem && !xfer_q.wr && xfer_q.low && (cnt >= CNT_W'(2)));
                smemw_n = !( xfer_q.mem &&  xfer_q.wr && xfer_q.low && (cnt >= CNT_W'(2)));
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/isa_cmd_timer_chk.sv
module isa_cmd_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic iochrdy,
    input logic ior_n,
    input logic iow_n,
    input logic memr_n,
    input logic memw_n,
    input logic smemr_n,
    input logic smemw_n,
    input logic done
);
    logic cmd_on;
    assign cmd_on = !(ior_n && iow_n && memr_n && memw_n);

    a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_on |-> ($countones({~ior_n, ~iow_n, ~memr_n, ~memw_n}) == 1));

    a_r3_min_two_clocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_on && !$past(cmd_on)) |=> cmd_on);

    a_r5_wait_extends: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_on && !iochrdy) |=> cmd_on);

    a_r7_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_on |=> (cmd_on || done));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_on);

    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !cmd_on);

    a_r9_smemr_sub: assert property (@(posedge clk) disable iff (!rst_n)
        !smemr_n |-> !memr_n);

    a_r9_smemw_sub: assert property (@(posedge clk) disable iff (!rst_n)
        !smemw_n |-> !memw_n);

    a_r9_smem_lag: assert property (@(posedge clk) disable iff (!rst_n)
        ((!memr_n && $past(memr_n)) || (!memw_n && $past(memw_n))) |-> (smemr_n && smemw_n));
endmodule

bind isa_cmd_timer isa_cmd_timer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .iochrdy (iochrdy),
    .ior_n   (ior_n),
    .iow_n   (iow_n),
    .memr_n  (memr_n),
    .memw_n  (memw_n),
    .smemr_n (smemr_n),
    .smemw_n (smemw_n),
    .done    (done)
);

// File: tb/sim_isa_cmd_timer.sv
module sim_isa_cmd_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, is_mem = 1'b0, is_wr = 1'b0;
    logic        memcs16_n = 1'b1, iocs16_n = 1'b1;
    logic [23:0] addr = '0;
    logic        iochrdy = 1'b1, zerows_n = 1'b1;
    logic        ior_n, iow_n, memr_n, memw_n, smemr_n, smemw_n, done;
    int          n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    isa_cmd_timer u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .is_mem(is_mem), .is_wr(is_wr),
        .memcs16_n(memcs16_n), .iocs16_n(iocs16_n), .addr(addr),
        .iochrdy(iochrdy), .zerows_n(zerows_n),
        .ior_n(ior_n), .iow_n(iow_n), .memr_n(memr_n), .memw_n(memw_n),
        .smemr_n(smemr_n), .smemw_n(smemw_n), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    function automatic int strobes();
        return {ior_n, iow_n, memr_n, memw_n};
    endfunction

    // mode 0: plain, 1: start pulse during command, 2: start during done clock
    task automatic run_one(input bit m, input bit w, input bit wide, input bit other,
                           input bit low, input bit zw, input int a, input int n,
                           input int mode);
        int    base, exp_len, len, exp_strb, bad_strb, bad_smem;
        string req;
        if (m && wide)  base = zw ? 2 : 3;
        else if (m)     base = zw ? 3 : 6;
        else if (wide)  base = 6;
        else            base = zw ? 3 : 6;
        exp_len = (n > 0 && a <= base && base <= a + n - 1) ? a + n : base;
        if (n > 0 && a <= base && base <= a + n - 1) req = "R5";
        else if (zw && !m && wide)                 req = "R4";
        else if (zw)                               req = "R3";
        else                                       req = "R2";
        if (other != wide) req = {req, "/R6"};
        exp_strb = {!(!m && !w), !(!m && w), !(m && !w), !(m && w)};

        @(negedge clk);
        is_mem = m; is_wr = w;
        memcs16_n = m ? !wide : other;
        iocs16_n  = m ? other : !wide;
        addr = low ? 24'h0ABCDE : 24'h3ABCDE;
        start = 1'b1; iochrdy = 1'b1; zerows_n = 1'b1;
        @(negedge clk);
        start = 1'b0;
        len = 0; bad_strb = 0; bad_smem = 0;
        for (int k = 1; k <= 40; k++) begin
            if (strobes() == 4'hF) break;
            len = k;
            if (strobes() != exp_strb) bad_strb++;
            if (smemr_n != !(m && !w && low && k >= 2)) bad_smem++;
            if (smemw_n != !(m &&  w && low && k >= 2)) bad_smem++;
            iochrdy  = !(n > 0 && k >= a && k < a + n);
            zerows_n = !zw;
            if (mode == 1 && k == 2) begin
                start = 1'b1; is_mem = !m; is_wr = !w;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        chk(bad_strb == 0, "R1 strobe select", bad_strb, 0);
        chk(bad_smem == 0, "R9 standard memory strobe", bad_smem, 0);
        chk(len == exp_len, req, len, exp_len);
        chk(done == 1'b1, "R7 done after command", done, 1);
        start = 1'b0; iochrdy = 1'b1; zerows_n = 1'b1;
        if (mode == 2) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R7 done one clock", done, 0);
        chk(strobes() == 4'hF, (mode != 0) ? "R8 start ignored while busy" : "R7 idle after done",
            strobes(), 15);
    endtask

    initial begin
        #(8 * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(strobes() == 4'hF && smemr_n && smemw_n, "R10 reset strobes", strobes(), 15);
        chk(done == 1'b0, "R10 reset done", done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(strobes() == 4'hF && done == 1'b0, "R10 idle after reset", strobes(), 15);
        for (int m = 0; m < 2; m++)
        for (int w = 0; w < 2; w++)
        for (int wd = 0; wd < 2; wd++)
        for (int o = 0; o < 2; o++)
        for (int lo = 0; lo < 2; lo++)
        for (int z = 0; z < 2; z++)
        for (int a = 1; a <= 4; a++)
        for (int n = 0; n <= 3; n++) begin
            run_one(m[0], w[0], wd[0], o[0], lo[0], z[0], a, n,
                    (n == 0 && a == 1) ? 1 : ((n == 0 && a == 2) ? 2 : 0));
        end
        summary();
    end
endmodule